// File: doc/BRIEF.md
# Receive Buffer Pool Allocator with Public Fallback

This block hands out packet buffer handles so that an interface's receive ring can be refilled after each arriving packet. It holds two free lists of buffer indices, each kept in first-in first-out order. The private list belongs to one interface and has a fixed population. The public list is shared. A refill request is served from the private list when it can be. When the private list is empty, the request is served from the public list and a fallback counter advances. When neither list has a buffer, the packet is refused, an ignore counter advances, and the interface is shut off for a programmable number of cycles.

Buffers move only as indices, and packet data is never copied. Each handle carries an origin bit. When a handle is freed it goes back to the list named by that bit, even if other buffers have been handed out and returned in between. A request that arrives while the input hold queue is full is dropped before either list is touched.

Top module: `buf_pool_alloc`

## Requirements
- R1: After reset, the private list holds indices 0 to PRIV_DEPTH-1 and the public list holds indices PRIV_DEPTH to PRIV_DEPTH+PUB_DEPTH-1, each in ascending order. Both counters are 0, and throttleActive, grantValid and dropValid are low.
- R2: A request sampled on a rising edge gives, in the following cycle, exactly one of grantValid or dropValid for one cycle. Without a request both stay low.
- R3: A request with holdQueueFull high is dropped with dropCause 1. It leaves both lists and both counters unchanged. This check comes before the throttle and the lists.
- R4: When the private list is not empty, a request is granted its oldest entry. The handle's top bit (bit 4 at default parameters) is 0, and the lower bits carry the index.
- R5: When the private list is empty and the public list is not, a request is granted the oldest public entry with handle top bit 1, and fallbackCount increases by one.
- R6: When both lists are empty, a request is dropped with dropCause 3, ignoreCount increases by one, and the throttle is loaded with throttleCycles.
- R7: After an ignore, throttleActive is high for exactly throttleCycles cycles, starting in the cycle after the ignore. While it is high, requests are dropped with dropCause 2 and change no list and no counter. A throttleCycles of 0 gives no throttle.
- R8: A freed handle is appended to the tail of the list named by its top bit. Freed buffers are granted again in the order they were freed.
- R9: fallbackCount and ignoreCount are 16 bits wide and hold at 0xFFFF once they reach it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Refill request for one receive ring slot |
| holdQueueFull | input | 1 | Input hold queue has no room |
| throttleCycles | input | THR_W | Throttle length in cycles after an ignore |
| freeValid | input | 1 | Return a buffer handle |
| freeHandle | input | IDX_W+1 | Returned handle: origin bit on top, index below |
| grantValid | output | 1 | Request granted, one cycle pulse |
| grantHandle | output | IDX_W+1 | Granted handle |
| dropValid | output | 1 | Request refused, one cycle pulse |
| dropCause | output | 2 | 1 hold full, 2 throttled, 3 both lists empty |
| throttleActive | output | 1 | Interface refuses requests |
| fallbackCount | output | CNT_W | Grants served from the public list |
| ignoreCount | output | CNT_W | Requests refused for lack of buffers |

## Verification
The bench drains the private list, then the public list, and then requests again so that both lists are empty. A design that skipped the fallback or granted from an empty list would show up as a wrong handle or a missing drop. It measures the throttle window, where an error of one cycle in either direction is a typical slip, and it checks that a zero length gives no window at all. It returns handles out of order across both origins, behind a request dropped for a full hold queue. A design that recycled into the wrong list, or took a buffer on a hold drop, would then grant the wrong handle. It also drives each counter past 0xFFFF; a design that wraps would read back a small value.

// File: rtl/bpa_pkg.sv
package bpa_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_HOLD     = 2'd1,
    CAUSE_THROTTLE = 2'd2,
    CAUSE_EMPTY    = 2'd3
  } dropCause_e;

  typedef struct packed {
    logic       popPriv;
    logic       popPub;
    logic       pushPriv;
    logic       pushPub;
    logic       grant;
    logic       drop;
    logic       bumpFallback;
    logic       bumpIgnore;
    logic       startThrottle;
    dropCause_e cause;
  } ctrlStrobes_t;

endpackage

// File: rtl/bpa_free_fifo.sv
module bpa_free_fifo #(
  parameter int DEPTH = 4,
  parameter int BASE  = 0,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pop,
  input  logic             push,
  input  logic [IDX_W-1:0] pushIdx,
  output logic [IDX_W-1:0] headIdx,
  output logic             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [IDX_W-1:0] mem [DEPTH];
  logic [PW-1:0]    rdPtr, wrPtr;
  logic [CW-1:0]    count;
  logic             doPop, doPush;

  assign empty   = (count == '0);
  assign headIdx = mem[rdPtr];
  assign doPop   = pop && !empty;
  assign doPush  = push && ((count != CW'(DEPTH)) || doPop);

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= IDX_W'(BASE + i);
      rdPtr <= '0;
      wrPtr <= '0;
      count <= CW'(DEPTH);
    end else begin
      if (doPush) begin
        mem[wrPtr] <= pushIdx;
        wrPtr      <= nextPtr(wrPtr);
      end
      if (doPop) rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/bpa_sat_counter.sv
module bpa_sat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rstN)                       count <= '0;
    else if (bump && (count != '1))  count <= count + 1'b1;
  end
endmodule

// File: rtl/bpa_control.sv
module bpa_control
  import bpa_pkg::*;
#(
  parameter int HANDLE_W = 5
) (
  input  logic                reqValid,
  input  logic                holdQueueFull,
  input  logic                throttleActive,
  input  logic                privEmpty,
  input  logic                pubEmpty,
  input  logic                freeValid,
  input  logic                freeTag,
  output ctrlStrobes_t        st
);
  logic accept;

  always_comb begin
    accept           = reqValid && !holdQueueFull && !throttleActive;
    st               = '0;
    st.popPriv       = accept && !privEmpty;
    st.popPub        = accept && privEmpty && !pubEmpty;
    st.bumpFallback  = st.popPub;
    st.bumpIgnore    = accept && privEmpty && pubEmpty;
    st.startThrottle = st.bumpIgnore;
    st.grant         = st.popPriv || st.popPub;
    st.drop          = reqValid && !st.grant;
    if (holdQueueFull)       st.cause = CAUSE_HOLD;
    else if (throttleActive) st.cause = CAUSE_THROTTLE;
    else                     st.cause = CAUSE_EMPTY;
    st.pushPriv      = freeValid && !freeTag;
    st.pushPub       = freeValid && freeTag;
  end
endmodule

// File: rtl/bpa_datapath.sv
module bpa_datapath
  import bpa_pkg::*;
#(
  parameter int PRIV_DEPTH = 4,
  parameter int PUB_DEPTH  = 8,
  parameter int IDX_W      = 4,
  parameter int CNT_W      = 16,
  parameter int THR_W      = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       st,
  input  logic [IDX_W-1:0]   freeIdx,
  input  logic [THR_W-1:0]   throttleCycles,
  output logic               privEmpty,
  output logic               pubEmpty,
  output logic               throttleActive,
  output logic               grantValid,
  output logic [IDX_W:0]     grantHandle,
  output logic               dropValid,
  output logic [1:0]         dropCause,
  output logic [CNT_W-1:0]   fallbackCount,
  output logic [CNT_W-1:0]   ignoreCount
);
  logic [1:0]       popV, pushV, emptyV;
  logic [IDX_W-1:0] headV [2];
  logic [THR_W-1:0] thrRem;

  assign popV  = {st.popPub,  st.popPriv};
  assign pushV = {st.pushPub, st.pushPriv};

  for (genvar p = 0; p < 2; p++) begin : g_pool
    localparam int DEP  = (p == 0) ? PRIV_DEPTH : PUB_DEPTH;
    localparam int BASE = (p == 0) ? 0 : PRIV_DEPTH;
    bpa_free_fifo #(.DEPTH(DEP), .BASE(BASE), .IDX_W(IDX_W)) fifo_i (
      .clk(clk), .rstN(rstN), .pop(popV[p]), .push(pushV[p]),
      .pushIdx(freeIdx), .headIdx(headV[p]), .empty(emptyV[p])
    );
  end

  assign privEmpty = emptyV[0];
  assign pubEmpty  = emptyV[1];

  bpa_sat_counter #(.CNT_W(CNT_W)) fallbackCnt_i (
    .clk(clk), .rstN(rstN), .bump(st.bumpFallback), .count(fallbackCount));
  bpa_sat_counter #(.CNT_W(CNT_W)) ignoreCnt_i (
    .clk(clk), .rstN(rstN), .bump(st.bumpIgnore), .count(ignoreCount));

  always_ff @(posedge clk) begin
    if (!rstN)                 thrRem <= '0;
    else if (st.startThrottle) thrRem <= throttleCycles;
    else if (thrRem != '0)     thrRem <= thrRem - 1'b1;
  end
  assign throttleActive = (thrRem != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantValid  <= 1'b0;
      grantHandle <= '0;
      dropValid   <= 1'b0;
      dropCause   <= CAUSE_NONE;
    end else begin
      grantValid <= st.grant;
      if (st.popPriv)     grantHandle <= {1'b0, headV[0]};
      else if (st.popPub) grantHandle <= {1'b1, headV[1]};
      dropValid  <= st.drop;
      dropCause  <= st.drop ? st.cause : CAUSE_NONE;
    end
  end
endmodule

// File: rtl/buf_pool_alloc.sv
module buf_pool_alloc
  import bpa_pkg::*;
#(
  parameter int  PRIV_DEPTH = 4,
  parameter int  PUB_DEPTH  = 8,
  parameter int  CNT_W      = 16,
  parameter int  THR_W      = 16,
  localparam int IDX_W      = $clog2(PRIV_DEPTH + PUB_DEPTH),
  localparam int HANDLE_W   = IDX_W + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                holdQueueFull,
  input  logic [THR_W-1:0]    throttleCycles,
  input  logic                freeValid,
  input  logic [HANDLE_W-1:0] freeHandle,
  output logic                grantValid,
  output logic [HANDLE_W-1:0] grantHandle,
  output logic                dropValid,
  output logic [1:0]          dropCause,
  output logic                throttleActive,
  output logic [CNT_W-1:0]    fallbackCount,
  output logic [CNT_W-1:0]    ignoreCount
);
  ctrlStrobes_t st;
  logic         privEmpty, pubEmpty;

  bpa_control #(.HANDLE_W(HANDLE_W)) ctrl_i (
    .reqValid(reqValid), .holdQueueFull(holdQueueFull),
    .throttleActive(throttleActive), .privEmpty(privEmpty), .pubEmpty(pubEmpty),
    .freeValid(freeValid), .freeTag(freeHandle[HANDLE_W-1]), .st(st));

  bpa_datapath #(.PRIV_DEPTH(PRIV_DEPTH), .PUB_DEPTH(PUB_DEPTH), .IDX_W(IDX_W),
                 .CNT_W(CNT_W), .THR_W(THR_W)) dp_i (
    .clk(clk), .rstN(rstN), .st(st), .freeIdx(freeHandle[IDX_W-1:0]),
    .throttleCycles(throttleCycles), .privEmpty(privEmpty), .pubEmpty(pubEmpty),
    .throttleActive(throttleActive), .grantValid(grantValid),
    .grantHandle(grantHandle), .dropValid(dropValid), .dropCause(dropCause),
    .fallbackCount(fallbackCount), .ignoreCount(ignoreCount));
endmodule

// File: rtl/buf_pool_alloc_chk.sv
module buf_pool_alloc_chk #(
  parameter int HANDLE_W = 5,
  parameter int CNT_W    = 16,
  parameter int THR_W    = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic                holdQueueFull,
  input logic [THR_W-1:0]    throttleCycles,
  input logic                throttleActive,
  input logic                grantValid,
  input logic [HANDLE_W-1:0] grantHandle,
  input logic                dropValid,
  input logic [1:0]          dropCause,
  input logic [CNT_W-1:0]    fallbackCount,
  input logic [CNT_W-1:0]    ignoreCount,
  input logic                privEmpty,
  input logic                pubEmpty
);
  logic open;
  assign open = reqValid && !holdQueueFull && !throttleActive;

  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    !(grantValid && dropValid));

  a_r2_request_answered: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (grantValid || dropValid));

  a_r3_hold_drop: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && holdQueueFull) |=> (dropValid && dropCause == 2'd1
      && $stable(fallbackCount) && $stable(ignoreCount)));

  a_r4_private_first: assert property (@(posedge clk) disable iff (!rstN)
    (open && !privEmpty) |=> (grantValid && !grantHandle[HANDLE_W-1]));

  a_r5_public_fallback: assert property (@(posedge clk) disable iff (!rstN)
    (open && privEmpty && !pubEmpty) |=> (grantValid && grantHandle[HANDLE_W-1]
      && (fallbackCount == $past(fallbackCount) + 1'b1 || $past(fallbackCount) == '1)));

  a_r6_ignore_drop: assert property (@(posedge clk) disable iff (!rstN)
    (open && privEmpty && pubEmpty) |=> (dropValid && dropCause == 2'd3
      && (ignoreCount == $past(ignoreCount) + 1'b1 || $past(ignoreCount) == '1)));

  a_r7_throttle_start: assert property (@(posedge clk) disable iff (!rstN)
    (open && privEmpty && pubEmpty && throttleCycles != '0) |=> throttleActive);

  a_r7_throttle_refuse: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !holdQueueFull && throttleActive) |=>
      (dropValid && dropCause == 2'd2 && $stable(ignoreCount)));

  a_r9_fallback_hold: assert property (@(posedge clk) disable iff (!rstN)
    (fallbackCount == '1) |=> (fallbackCount == '1));

  a_r9_ignore_hold: assert property (@(posedge clk) disable iff (!rstN)
    (ignoreCount == '1) |=> (ignoreCount == '1));
endmodule

bind buf_pool_alloc buf_pool_alloc_chk #(.HANDLE_W(HANDLE_W), .CNT_W(CNT_W), .THR_W(THR_W)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .holdQueueFull(holdQueueFull),
  .throttleCycles(throttleCycles), .throttleActive(throttleActive),
  .grantValid(grantValid), .grantHandle(grantHandle), .dropValid(dropValid),
  .dropCause(dropCause), .fallbackCount(fallbackCount), .ignoreCount(ignoreCount),
  .privEmpty(privEmpty), .pubEmpty(pubEmpty));

// File: tb/buf_pool_alloc_tb_top.sv
module buf_pool_alloc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PUB_TAG    = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        holdQueueFull = 1'b0;
  logic [15:0] throttleCycles = '0;
  logic        freeValid = 1'b0;
  logic [4:0]  freeHandle = '0;
  logic        grantValid, dropValid, throttleActive;
  logic [4:0]  grantHandle;
  logic [1:0]  dropCause;
  logic [15:0] fallbackCount, ignoreCount;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  buf_pool_alloc dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .holdQueueFull(holdQueueFull),
    .throttleCycles(throttleCycles), .freeValid(freeValid), .freeHandle(freeHandle),
    .grantValid(grantValid), .grantHandle(grantHandle), .dropValid(dropValid),
    .dropCause(dropCause), .throttleActive(throttleActive),
    .fallbackCount(fallbackCount), .ignoreCount(ignoreCount));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic reqOnce(input logic hold);
    @(negedge clk);
    reqValid = 1'b1;
    holdQueueFull = hold;
    @(negedge clk);
    reqValid = 1'b0;
    holdQueueFull = 1'b0;
  endtask

  task automatic freeOne(input int h);
    @(negedge clk);
    freeValid = 1'b1;
    freeHandle = 5'(h);
    @(negedge clk);
    freeValid = 1'b0;
  endtask

  task automatic expectGrant(input string req, input int h);
    chk(req, "grantValid", int'(grantValid), 1);
    chk(req, "dropValid", int'(dropValid), 0);
    chk(req, "grantHandle", int'(grantHandle), h);
  endtask

  task automatic expectDrop(input string req, input int cause);
    chk(req, "grantValid", int'(grantValid), 0);
    chk(req, "dropValid", int'(dropValid), 1);
    chk(req, "dropCause", int'(dropCause), cause);
  endtask

  task automatic testReset();
    chk("R1", "grantValid", int'(grantValid), 0);
    chk("R1", "dropValid", int'(dropValid), 0);
    chk("R1", "throttleActive", int'(throttleActive), 0);
    chk("R1", "fallbackCount", int'(fallbackCount), 0);
    chk("R1", "ignoreCount", int'(ignoreCount), 0);
  endtask

  task automatic testPrivateOrder();
    for (int i = 0; i < 4; i++) begin
      reqOnce(1'b0);
      expectGrant("R4", i);
    end
    chk("R4", "fallbackCount", int'(fallbackCount), 0);
    @(negedge clk);
    chk("R2", "idle grantValid", int'(grantValid), 0);
    chk("R2", "idle dropValid", int'(dropValid), 0);
  endtask

  task automatic testFallback();
    for (int i = 0; i < 8; i++) begin
      reqOnce(1'b0);
      expectGrant("R5", PUB_TAG + 4 + i);
      chk("R5", "fallbackCount", int'(fallbackCount), i + 1);
    end
  endtask

  task automatic testIgnoreThrottle();
    int len = 0;
    throttleCycles = 16'd5;
    reqOnce(1'b0);
    expectDrop("R6", 3);
    chk("R6", "ignoreCount", int'(ignoreCount), 1);
    while (throttleActive && len < 100) begin
      len++;
      @(negedge clk);
    end
    chk("R7", "throttle length", len, 5);
  endtask

  task automatic testThrottleRefuse();
    throttleCycles = 16'd3;
    reqOnce(1'b0);
    expectDrop("R6", 3);
    chk("R6", "ignoreCount", int'(ignoreCount), 2);
    reqOnce(1'b0);
    expectDrop("R7", 2);
    chk("R7", "ignoreCount unchanged", int'(ignoreCount), 2);
    chk("R7", "fallbackCount unchanged", int'(fallbackCount), 8);
    while (throttleActive) @(negedge clk);
  endtask

  task automatic testZeroThrottle();
    throttleCycles = 16'd0;
    reqOnce(1'b0);
    expectDrop("R7", 3);
    chk("R7", "no throttle", int'(throttleActive), 0);
    reqOnce(1'b0);
    expectDrop("R7", 3);
    chk("R7", "ignoreCount", int'(ignoreCount), 4);
  endtask

  task automatic testHoldAndReturn();
    freeOne(3);
    freeOne(1);
    freeOne(PUB_TAG + 6);
    reqOnce(1'b1);
    expectDrop("R3", 1);
    chk("R3", "ignoreCount", int'(ignoreCount), 4);
    chk("R3", "fallbackCount", int'(fallbackCount), 8);
    reqOnce(1'b0);
    expectGrant("R8", 3);
    reqOnce(1'b0);
    expectGrant("R8", 1);
    reqOnce(1'b0);
    expectGrant("R8", PUB_TAG + 6);
    chk("R8", "fallbackCount", int'(fallbackCount), 9);
  endtask

  task automatic testSaturation();
    int bad = 0;
    freeOne(PUB_TAG + 4);
    freeOne(PUB_TAG + 5);
    @(negedge clk);
    reqValid = 1'b1;
    for (int i = 0; i < 65540; i++) begin
      @(negedge clk);
      if (!grantValid) bad++;
      freeValid = grantValid;
      freeHandle = grantHandle;
    end
    @(negedge clk);
    if (!grantValid) bad++;
    reqValid = 1'b0;
    freeValid = grantValid;
    freeHandle = grantHandle;
    @(negedge clk);
    freeValid = 1'b0;
    chk("R9", "grants in fallback loop missed", bad, 0);
    chk("R9", "fallbackCount saturated", int'(fallbackCount), 65535);
    reqOnce(1'b0);
    reqOnce(1'b0);
    expectGrant("R9", grantHandle);
    chk("R9", "fallbackCount holds", int'(fallbackCount), 65535);
    throttleCycles = 16'd0;
    @(negedge clk);
    reqValid = 1'b1;
    repeat (65540) @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    chk("R9", "ignoreCount saturated", int'(ignoreCount), 65535);
    chk("R9", "no throttle after saturation", int'(throttleActive), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPrivateOrder();
    testFallback();
    testIgnoreThrottle();
    testThrottleRefuse();
    testZeroThrottle();
    testHoldAndReturn();
    testSaturation();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule